// File: doc/BRIEF.md
# Two-Channel Memory-to-Memory DMA Controller

This block moves bytes from one location to another inside a 64 KB address space, with no help from the processor once a channel is programmed. It has two channels. Each one holds a working source address, a working destination address and a working byte count, and each of these has a reload latch beside it. A transfer is started by a rising edge on one selected hardware request line or by a software trigger bit. Every byte costs two bus cycles: the block reads the source into a holding register, then writes that register to the destination.

The processor reaches both channels through one small register window. Bit 7 of a shared index/status register picks which channel the window addresses. The same register also carries one underflow flag per channel, and these are cleared by writing 1. The block drives a plain byte-wide memory bus and samples read data in the same cycle it asserts the read strobe. An external arbiter gives it the bus through a grant input, and each channel has its own interrupt line that pulses when its count underflows.

Top module: `dma2_ctrl`

## Requirements
- R1: After reset, neither memory strobe is active, both interrupt lines are low, and the status register (address 8) reads 0x00.
- R2: Bit 7 of the status register selects the channel reached through window addresses 0 to 7: 0 gives channel 0, 1 gives channel 1. Each channel keeps its own values, and a window read returns the selected channel's working register one cycle after the address is presented. The window layout is: 0 control, 1 step, 2/3 source low/high, 4/5 destination low/high, 6/7 count low/high.
- R3: Each byte takes exactly two cycles. In the first, mem_re is high with the source address on mem_addr. In the next, mem_we is high with the destination address, and mem_wdata carries the byte read in the cycle before.
- R4: Step register bits 1:0 set the source step and bits 3:2 set the destination step, both applied after every byte. The codes are 0 for +1, 1 for −1, and 2 or 3 for no change. Addresses wrap modulo 65,536.
- R5: The count decrements once per byte, so a count of N moves N+1 bytes. On the byte where the count goes from 0x0000 to 0xFFFF, the channel's status flag is set (bit 0 for channel 0, bit 1 for channel 1) and its irq_o bit is high for exactly one cycle.
- R6: With control bit 1 clear, each request moves one byte. With control bit 1 set, one request moves bytes back to back, one write every two cycles, until the count underflows.
- R7: A channel transfers only while its enable (control bit 0) is set and bus_grant_i is high. A request is either a rising edge on req_i[sel], where sel is control bits 7:4, which is held pending until served, or a write of 1 to control bit 3, which reads back 0 once its transfer starts. Level-high requests and edges on other lines start nothing.
- R8: When both channels have a request waiting at the same time, channel 0 moves its byte first.
- R9: When control bit 2 is clear, a window write updates both the latch and the working register, and an underflow clears the channel's enable. When control bit 2 is set, a window write updates only the latch, and an underflow reloads the working source, destination and count from the latches while the channel stays enabled.
- R10: Writing 1 to a status flag bit clears that flag. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr_i | input | 4 | Register address: 0-7 channel window, 8 index/status |
| cpu_wr_i | input | 1 | Register write strobe |
| cpu_wdata_i | input | 8 | Register write data |
| cpu_rdata_o | output | 8 | Register read data, one cycle after the address |
| req_i | input | NREQ | Hardware request lines |
| bus_grant_i | input | 1 | Bus granted to the block; new transfers start only while high |
| bus_busy_o | output | 1 | A byte or burst is in progress |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data (holding register) |
| mem_rdata_i | input | 8 | Memory read data, valid in the mem_re_o cycle |
| irq_o | output | 2 | Per-channel underflow interrupt pulse |

## Verification
The hardest case to reach from the ports is two channels both waiting at the same byte boundary. A software write can only arm one channel per cycle, so the two would otherwise arrive one after the other. The bench holds the grant low, arms both channels on the same hardware request line, pulses that line, and then releases the grant. An underflow that reloads the channel at the end of a burst is also hard to observe, because the reloaded values only show through read-back. The bench writes a latch while reload-on-underflow is on, runs a burst to underflow, and reads the working registers back before starting again.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int NCH    = 2;

  localparam logic [2:0] REG_CTRL   = 3'd0;
  localparam logic [2:0] REG_STEP   = 3'd1;
  localparam logic [2:0] REG_SRC_LO = 3'd2;
  localparam logic [2:0] REG_SRC_HI = 3'd3;
  localparam logic [2:0] REG_DST_LO = 3'd4;
  localparam logic [2:0] REG_DST_HI = 3'd5;
  localparam logic [2:0] REG_CNT_LO = 3'd6;
  localparam logic [2:0] REG_CNT_HI = 3'd7;
  localparam logic [3:0] STATUS_ADDR = 4'd8;

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  typedef enum logic [1:0] {ENG_IDLE, ENG_RD, ENG_WR} eng_state_e;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [1:0] s);
    case (s)
      2'd0:    return a + ADDR_ONE;
      2'd1:    return a - ADDR_ONE;
      default: return a;
    endcase
  endfunction
endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
  import dma2_pkg::*;
#(
  parameter int NREQ = 16,
  localparam int SELW = $clog2(NREQ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        reg_sel,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic [NREQ-1:0]   req_vec,
  input  logic              start_i,
  input  logic              adv_i,
  output logic              ready_o,
  output logic              burst_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o
);
  logic              en, burst, autold, swt, pend, req_q;
  logic [SELW-1:0]   sel;
  logic [1:0]        sstep, dstep;
  logic [ADDR_W-1:0] src, dst, src_l, dst_l;
  logic [CNT_W-1:0]  cnt, cnt_l;
  logic              req_line, req_edge, wr_ctrl;

  assign req_line = req_vec[sel];
  assign req_edge = req_line & ~req_q;
  assign wr_ctrl  = wr_en && (reg_sel == REG_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; burst <= 1'b0; autold <= 1'b0; swt <= 1'b0;
      pend <= 1'b0; req_q <= 1'b0; sel <= '0;
      sstep <= 2'd0; dstep <= 2'd0;
      src <= '0; dst <= '0; cnt <= '0;
      src_l <= '0; dst_l <= '0; cnt_l <= '0;
    end else begin
      req_q <= req_line;
      if (start_i) begin
        pend <= 1'b0;
        swt  <= 1'b0;
      end
      if (req_edge && en) pend <= 1'b1;
      if (adv_i) begin
        if (last_o && autold) begin
          src <= src_l;
          dst <= dst_l;
          cnt <= cnt_l;
        end else begin
          src <= step_addr(src, sstep);
          dst <= step_addr(dst, dstep);
          cnt <= cnt - CNT_ONE;
          if (last_o) begin
            en   <= 1'b0;
            pend <= 1'b0;
          end
        end
      end
      if (wr_en) begin
        case (reg_sel)
          REG_CTRL: begin
            en     <= wr_data[0];
            burst  <= wr_data[1];
            autold <= wr_data[2];
            swt    <= wr_data[3];
            sel    <= wr_data[4 +: SELW];
          end
          REG_STEP: begin
            sstep <= wr_data[1:0];
            dstep <= wr_data[3:2];
          end
          REG_SRC_LO: begin src_l[7:0]  <= wr_data; if (!autold) src[7:0]  <= wr_data; end
          REG_SRC_HI: begin src_l[15:8] <= wr_data; if (!autold) src[15:8] <= wr_data; end
          REG_DST_LO: begin dst_l[7:0]  <= wr_data; if (!autold) dst[7:0]  <= wr_data; end
          REG_DST_HI: begin dst_l[15:8] <= wr_data; if (!autold) dst[15:8] <= wr_data; end
          REG_CNT_LO: begin cnt_l[7:0]  <= wr_data; if (!autold) cnt[7:0]  <= wr_data; end
          default:    begin cnt_l[15:8] <= wr_data; if (!autold) cnt[15:8] <= wr_data; end
        endcase
      end
    end
  end

  assign ready_o = en & (pend | swt);
  assign burst_o = burst;
  assign last_o  = (cnt == '0);
  assign src_o   = src;
  assign dst_o   = dst;

  always_comb begin
    case (reg_sel)
      REG_CTRL:   rd_data = 8'({sel, swt, autold, burst, en});
      REG_STEP:   rd_data = {4'b0000, dstep, sstep};
      REG_SRC_LO: rd_data = src[7:0];
      REG_SRC_HI: rd_data = src[15:8];
      REG_DST_LO: rd_data = dst[7:0];
      REG_DST_HI: rd_data = dst[15:8];
      REG_CNT_LO: rd_data = cnt[7:0];
      default:    rd_data = cnt[15:8];
    endcase
  end

  // R7: an accepted software trigger reads back clear
  p_swt_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (start_i && !wr_ctrl) |=> !swt);
  // R9: without reload-on-underflow the channel turns itself off
  p_disable_r9: assert property (@(posedge clk) disable iff (rst)
    (adv_i && last_o && !autold && !wr_ctrl) |=> !en);
  // R9: with reload-on-underflow the count returns to its latch
  p_reload_r9: assert property (@(posedge clk) disable iff (rst)
    (adv_i && last_o && autold && !wr_en) |=> (cnt == $past(cnt_l)));
  // R5: one decrement per byte moved
  p_count_dec_r5: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !last_o && !wr_en) |=> (cnt == $past(cnt) - CNT_ONE));
endmodule

// File: rtl/dma2_engine.sv
module dma2_engine
  import dma2_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      grant_i,
  input  logic [NCH-1:0]            ready_i,
  input  logic [NCH-1:0]            burst_i,
  input  logic [NCH-1:0]            last_i,
  input  logic [NCH-1:0][ADDR_W-1:0] src_i,
  input  logic [NCH-1:0][ADDR_W-1:0] dst_i,
  input  logic [7:0]                mem_rdata_i,
  output logic [NCH-1:0]            start_o,
  output logic [NCH-1:0]            adv_o,
  output logic                      mem_re_o,
  output logic                      mem_we_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [7:0]                mem_wdata_o,
  output logic                      busy_o
);
  eng_state_e state;
  logic       ch;
  logic [7:0] temp;
  logic       go;

  assign go      = (state == ENG_IDLE) && grant_i && (|ready_i);
  assign start_o = go ? (ready_i[0] ? 2'b01 : 2'b10) : 2'b00;
  assign adv_o   = (state == ENG_WR) ? (ch ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ENG_IDLE;
      ch    <= 1'b0;
      temp  <= 8'h00;
    end else begin
      case (state)
        ENG_IDLE: if (go) begin
          ch    <= ~ready_i[0];
          state <= ENG_RD;
        end
        ENG_RD: begin
          temp  <= mem_rdata_i;
          state <= ENG_WR;
        end
        default: state <= (burst_i[ch] && !last_i[ch]) ? ENG_RD : ENG_IDLE;
      endcase
    end
  end

  assign mem_re_o    = (state == ENG_RD);
  assign mem_we_o    = (state == ENG_WR);
  assign mem_addr_o  = (state == ENG_RD) ? src_i[ch] : dst_i[ch];
  assign mem_wdata_o = temp;
  assign busy_o      = (state != ENG_IDLE);

  // R3: strobes never overlap; every read is followed by its write
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    !(mem_re_o && mem_we_o));
  p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (rst)
    mem_re_o |=> mem_we_o);
  p_wr_data_r3: assert property (@(posedge clk) disable iff (rst)
    mem_re_o |=> (mem_wdata_o == $past(mem_rdata_i)));
  // R8: channel 0 wins a free bus
  p_ch0_first_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_IDLE && grant_i && ready_i[0]) |=> (mem_re_o && mem_addr_o == $past(src_i[0])));
endmodule

// File: rtl/dma2_ctrl.sv
module dma2_ctrl
  import dma2_pkg::*;
#(
  parameter int NREQ = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cpu_addr_i,
  input  logic              cpu_wr_i,
  input  logic [7:0]        cpu_wdata_i,
  output logic [7:0]        cpu_rdata_o,
  input  logic [NREQ-1:0]   req_i,
  input  logic              bus_grant_i,
  output logic              bus_busy_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [NCH-1:0]    irq_o
);
  logic                       idx;
  logic [NCH-1:0]             uf;
  logic [NCH-1:0]             ready_w, burst_w, last_w, start_w, adv_w, uf_ev;
  logic [NCH-1:0][ADDR_W-1:0] src_w, dst_w;
  logic [NCH-1:0][7:0]        rd_w;
  logic                       win_wr, stat_wr;

  assign win_wr  = cpu_wr_i && !cpu_addr_i[3];
  assign stat_wr = cpu_wr_i && (cpu_addr_i == STATUS_ADDR);
  assign uf_ev   = adv_w & last_w;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dma2_chan #(.NREQ(NREQ)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (win_wr && (idx == 1'(c))),
      .reg_sel (cpu_addr_i[2:0]),
      .wr_data (cpu_wdata_i),
      .rd_data (rd_w[c]),
      .req_vec (req_i),
      .start_i (start_w[c]),
      .adv_i   (adv_w[c]),
      .ready_o (ready_w[c]),
      .burst_o (burst_w[c]),
      .last_o  (last_w[c]),
      .src_o   (src_w[c]),
      .dst_o   (dst_w[c])
    );
  end

  dma2_engine u_engine (
    .clk         (clk),
    .rst         (rst),
    .grant_i     (bus_grant_i),
    .ready_i     (ready_w),
    .burst_i     (burst_w),
    .last_i      (last_w),
    .src_i       (src_w),
    .dst_i       (dst_w),
    .mem_rdata_i (mem_rdata_i),
    .start_o     (start_w),
    .adv_o       (adv_w),
    .mem_re_o    (mem_re_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .busy_o      (bus_busy_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx         <= 1'b0;
      uf          <= '0;
      irq_o       <= '0;
      cpu_rdata_o <= 8'h00;
    end else begin
      if (stat_wr) idx <= cpu_wdata_i[7];
      uf    <= (stat_wr ? (uf & ~cpu_wdata_i[NCH-1:0]) : uf) | uf_ev;
      irq_o <= uf_ev;
      if (!cpu_addr_i[3])
        cpu_rdata_o <= rd_w[idx];
      else if (cpu_addr_i == STATUS_ADDR)
        cpu_rdata_o <= {idx, 5'b00000, uf};
      else
        cpu_rdata_o <= 8'h00;
    end
  end

  // R5: an interrupt is a single-cycle pulse and always comes with its flag
  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o[0] |=> !irq_o[0]);
  p_irq_flag_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o[1] |-> uf[1]);
  // R10: write-one clears the flag when no new underflow arrives
  p_w1c_r10: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && cpu_wdata_i[0] && !uf_ev[0]) |=> !uf[0]);
endmodule

// File: tb/dma2_ctrl_bench.sv
module dma2_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  cpu_addr;
  logic        cpu_wr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic [15:0] req;
  logic        grant, busy, mem_re, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [1:0]  irq;

  always #4 clk = ~clk;

  dma2_ctrl #(.NREQ(16)) u_dma2_ctrl (
    .clk(clk), .rst(rst), .cpu_addr_i(cpu_addr), .cpu_wr_i(cpu_wr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .req_i(req),
    .bus_grant_i(grant), .bus_busy_o(busy), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .irq_o(irq)
  );

  int checks = 0, errors = 0;
  int cyc = 0, rd_cyc = 0, nlog = 0;
  int irq_cnt [2];
  logic [15:0] rd_addr;
  logic [15:0] log_addr [0:63];
  logic [7:0]  log_data [0:63];
  int          log_cyc  [0:63];
  logic [7:0]  v;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [15:0] exp_a(input logic [15:0] base, input int st, input int k);
    if (st == 0) return base + 16'(k);
    if (st == 1) return base - 16'(k);
    return base;
  endfunction

  assign mem_rdata = pat(mem_addr);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (irq[0]) irq_cnt[0]++;
      if (irq[1]) irq_cnt[1]++;
      if (mem_re) begin
        rd_cyc  = cyc;
        rd_addr = mem_addr;
      end
      if (mem_we) begin
        // R3: write one cycle after read, carrying the byte read
        chk(cyc == rd_cyc + 1 && mem_wdata == pat(rd_addr), "R3 read-then-write",
            {8'h0, mem_wdata, 16'(cyc - rd_cyc)}, {8'h0, pat(rd_addr), 16'd1});
        if (nlog < 64) begin
          log_addr[nlog] = mem_addr;
          log_data[nlog] = mem_wdata;
          log_cyc[nlog]  = cyc;
        end
        nlog++;
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    cpu_addr = a;
    @(negedge clk);
    d = cpu_rdata;
  endtask

  task automatic prog(input int ch, input logic [15:0] s, input logic [15:0] d,
                      input logic [15:0] n, input logic [7:0] st, input logic [7:0] ctl);
    wr(4'd8, (ch == 1) ? 8'h80 : 8'h00);
    wr(4'd1, st);
    wr(4'd2, s[7:0]); wr(4'd3, s[15:8]);
    wr(4'd4, d[7:0]); wr(4'd5, d[15:8]);
    wr(4'd6, n[7:0]); wr(4'd7, n[15:8]);
    wr(4'd0, ctl);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int irqb;
    irq_cnt[0] = 0; irq_cnt[1] = 0;
    rst = 1'b1; cpu_addr = 4'd0; cpu_wr = 1'b0; cpu_wdata = 8'h00;
    req = 16'h0000; grant = 1'b1;
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    chk(!mem_re && !mem_we, "R1 strobes idle", {mem_re, mem_we}, 0);
    chk(irq == 2'b00, "R1 irq low", irq, 0);
    rd(4'd8, v);
    chk(v == 8'h00, "R1 status", v, 0);

    // R2: index bit steers the window
    wr(4'd8, 8'h00); wr(4'd3, 8'h12);
    wr(4'd8, 8'h80); wr(4'd3, 8'hAB);
    wr(4'd8, 8'h00); rd(4'd3, v);
    chk(v == 8'h12, "R2 ch0 window", v, 8'h12);
    wr(4'd8, 8'h80); rd(4'd3, v);
    chk(v == 8'hAB, "R2 ch1 window", v, 8'hAB);
    rd(4'd8, v);
    chk(v == 8'h80, "R2 index readback", v, 8'h80);

    // R4 R6 R5 R10: sweep source/destination steps in burst mode
    for (int s = 0; s < 3; s++) begin
      for (int d = 0; d < 3; d++) begin
        nlog = 0;
        irqb = irq_cnt[0];
        prog(0, 16'h3401, 16'hFFFE, 16'd2, 8'((d << 2) | s), 8'h0B);
        idle(16);
        chk(nlog == 3, "R5 count 2 moves 3 bytes", nlog, 3);
        for (int k = 0; k < 3; k++)
          chk(log_addr[k] == exp_a(16'hFFFE, d, k) && log_data[k] == pat(exp_a(16'h3401, s, k)),
              "R4 step addressing", {log_addr[k], log_data[k]},
              {exp_a(16'hFFFE, d, k), pat(exp_a(16'h3401, s, k))});
        for (int k = 1; k < 3; k++)
          chk(log_cyc[k] - log_cyc[k-1] == 2, "R6 burst back to back",
              log_cyc[k] - log_cyc[k-1], 2);
        chk(irq_cnt[0] == irqb + 1, "R5 one irq pulse", irq_cnt[0] - irqb, 1);
        rd(4'd8, v);
        chk(v == 8'h01, "R5 flag set", v, 8'h01);
        wr(4'd8, 8'h00);
        rd(4'd8, v);
        chk(v == 8'h01, "R10 write 0 keeps flag", v, 8'h01);
        wr(4'd8, 8'h01);
        rd(4'd8, v);
        chk(v == 8'h00, "R10 write 1 clears flag", v, 8'h00);
      end
    end

    // R6 R7 R9: single-byte mode on channel 1 with software triggers
    nlog = 0;
    irqb = irq_cnt[1];
    prog(1, 16'h0500, 16'h0600, 16'd2, 8'h00, 8'h09);
    idle(10);
    chk(nlog == 1, "R6 single byte per request", nlog, 1);
    rd(4'd0, v);
    chk(v == 8'h01, "R7 trigger self-clears", v, 8'h01);
    wr(4'd0, 8'h09); idle(10);
    wr(4'd0, 8'h09); idle(10);
    chk(nlog == 3 && log_addr[2] == 16'h0602, "R6 third single byte", log_addr[2], 16'h0602);
    chk(irq_cnt[1] == irqb + 1, "R5 ch1 irq", irq_cnt[1] - irqb, 1);
    rd(4'd8, v);
    chk(v == 8'h82, "R5 ch1 flag bit 1", v, 8'h82);
    rd(4'd0, v);
    chk(v == 8'h00, "R9 disabled on underflow", v, 8'h00);
    rd(4'd6, v);
    chk(v == 8'hFF, "R5 count wraps", v, 8'hFF);
    wr(4'd0, 8'h08); idle(10);
    chk(nlog == 3, "R7 disabled channel ignores trigger", nlog, 3);
    wr(4'd8, 8'h82);

    // R7: hardware request edge capture on line 5
    nlog = 0;
    prog(0, 16'h0700, 16'h0800, 16'd5, 8'h00, 8'h51);
    req[5] = 1'b1; idle(10);
    chk(nlog == 1, "R7 held level moves one byte", nlog, 1);
    req[3] = 1'b1; idle(10);
    chk(nlog == 1, "R7 unselected line ignored", nlog, 1);
    req[5] = 1'b0; req[3] = 1'b0; idle(2);
    grant = 1'b0;
    req[5] = 1'b1; idle(10);
    chk(nlog == 1, "R7 no transfer without grant", nlog, 1);
    grant = 1'b1; idle(10);
    chk(nlog == 2 && log_addr[1] == 16'h0801, "R7 pending served after grant",
        log_addr[1], 16'h0801);
    req[5] = 1'b0;

    // R8: simultaneous requests
    grant = 1'b0;
    prog(0, 16'h0900, 16'h0A00, 16'd5, 8'h00, 8'h61);
    prog(1, 16'h0B00, 16'h0C00, 16'd5, 8'h00, 8'h61);
    nlog = 0;
    req[6] = 1'b1; idle(3);
    grant = 1'b1; idle(12);
    chk(nlog == 2, "R8 both served", nlog, 2);
    chk(log_addr[0] == 16'h0A00, "R8 ch0 first", log_addr[0], 16'h0A00);
    chk(log_addr[1] == 16'h0C00, "R8 ch1 second", log_addr[1], 16'h0C00);
    req[6] = 1'b0;
    wr(4'd8, 8'h80); wr(4'd0, 8'h00);

    // R9: reload from latches after underflow
    prog(0, 16'h2000, 16'h3000, 16'd1, 8'h00, 8'h00);
    wr(4'd0, 8'h05);
    wr(4'd2, 8'h80);
    rd(4'd2, v);
    chk(v == 8'h00, "R9 latch-only write", v, 8'h00);
    nlog = 0;
    wr(4'd0, 8'h0F); idle(12);
    chk(nlog == 2 && log_addr[1] == 16'h3001 && log_data[1] == pat(16'h2001),
        "R9 burst before reload", {log_addr[1], log_data[1]}, {16'h3001, pat(16'h2001)});
    rd(4'd2, v);
    chk(v == 8'h80, "R9 source reloaded", v, 8'h80);
    rd(4'd4, v);
    chk(v == 8'h00, "R9 destination reloaded", v, 8'h00);
    rd(4'd6, v);
    chk(v == 8'h01, "R9 count reloaded", v, 8'h01);
    rd(4'd0, v);
    chk(v == 8'h07, "R9 stays enabled", v, 8'h07);
    nlog = 0;
    wr(4'd0, 8'h0F); idle(12);
    chk(log_addr[0] == 16'h3000 && log_data[0] == pat(16'h2080), "R9 runs from reload",
        {log_addr[0], log_data[0]}, {16'h3000, pat(16'h2080)});
    wr(4'd8, 8'h03);
    rd(4'd8, v);
    chk(v == 8'h00, "R10 both flags cleared", v, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule